// File: doc/BRIEF.md
# Burst SRAM Address Sequencer and Byte-Write Control

This block is the synchronous control front end of a burst-capable static memory. An address strobe captures an external start address and restarts a four-beat burst. An advance input then steps an internal beat counter, and the counter supplies the next three addresses by changing only the two lowest address bits. An order mode picks one of two beat orders. In interleaved order the low bits are the start bits XOR the beat index. In linear order the low bits count up from the start value and wrap modulo four. The mode is sampled only while reset is held. It defaults to interleaved when driven high, so a tie-high behaves as an unconnected pin would.

On every clock the block also decodes three write controls into one write enable per 9-bit byte lane. The active-low all-lane write has top priority. Below it, the active-low lane-write enable qualifies the per-lane active-low strobes. A small behavioural array of 18-bit words closes the loop. Write data and lane enables are captured on the same edge as the address they apply to, and they are committed at the edge that ends that cycle. Read data is flow-through: it comes combinationally from the current burst address.

The beat counter is a four-state machine. The states are BT_FIRST, BT_SECOND, BT_THIRD and BT_FOURTH. Its transitions are:
- LOAD: any state to BT_FIRST when the strobe is high.
- STEP: to the next state when advance is high and the strobe is low.
- WRAP: BT_FOURTH to BT_FIRST on advance.
- HOLD: no change when both inputs are low.

Top module: `burst_sram_front`

## Requirements
- R1: When `addr_load` is high at a rising edge, `burst_addr` equals the sampled `addr_in` after that edge, and the burst restarts at its first beat. This holds even in the middle of a burst.
- R2: When `addr_load` is low and `addr_adv` is high, the burst moves on one beat per edge. When both are low, `burst_addr` holds its value.
- R3: When `order_mode` was high during reset, beat k (k = 0..3) has low address bits equal to the start low bits XOR k.
- R4: When `order_mode` was low during reset, beat k has low address bits equal to (start low bits + k) mod 4.
- R5: Bits above bit 1 of `burst_addr` never change except on a load. An advance from the fourth beat returns to the first beat's address.
- R6: When `all_wr_n` is 0, both lanes of the captured address are written, whatever `lane_wr_en_n` and `lane_strb_n` show.
- R7: When `all_wr_n` and `lane_wr_en_n` are both 1, nothing is written, whatever `lane_strb_n` shows.
- R8: When `all_wr_n` is 1 and `lane_wr_en_n` is 0, lane i is written exactly when `lane_strb_n[i]` is 0. Lane 0 is data bits 8:0 and lane 1 is bits 17:9. With both strobes high, nothing is written.
- R9: `rdata` is the stored word at the current `burst_addr` in the same cycle. Write controls and `wdata` sampled at an edge apply to the address that edge establishes, and the word is stored at the following edge.
- R10: `order_mode` is sampled only while `rst` is high. Changes to it after reset do not alter the beat order.
- R11: Synchronous `rst` returns the burst to the first beat at address 0 and clears all lane write enables. A write captured just before reset is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| order_mode | input | 1 | Burst order, sampled in reset: 1 interleaved, 0 linear |
| addr_load | input | 1 | Load `addr_in` and restart the burst |
| addr_adv | input | 1 | Advance the burst by one beat |
| addr_in | input | ADDR_W (8) | External start address |
| all_wr_n | input | 1 | Active-low write of every lane |
| lane_wr_en_n | input | 1 | Active-low enable for the per-lane strobes |
| lane_strb_n | input | LANES (2) | Active-low per-lane write strobes |
| wdata | input | LANES*LANE_W (18) | Write data |
| rdata | output | LANES*LANE_W (18) | Flow-through read data |
| burst_addr | output | ADDR_W (8) | Address of the current beat |

## Verification
A load or advance sampled at an edge shows up on `burst_addr` right after that edge. `rdata` follows that address in the same cycle with no further register. A write sampled at an edge lands at the next edge, so its data is visible one cycle after the controls were applied. The driver changes inputs on the falling edge and pushes the outcome of the next rising edge, computed from a requirement-level model, into a queue. The monitor pops and compares that entry 2 ns after the rising edge, so each result is sampled exactly one edge after its stimulus.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    // Beat index of the current burst; the encoding is the beat number.
    typedef enum logic [1:0] {
        BT_FIRST  = 2'd0,
        BT_SECOND = 2'd1,
        BT_THIRD  = 2'd2,
        BT_FOURTH = 2'd3
    } beat_e;

    // Burst ordering, latched from the mode input during reset.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - 2;

    beat_e             beat_q;
    beat_e             beat_d;
    order_e            order_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_idx;
    logic [1:0]        low_bits;

    // State register: beat, captured start address, latched order.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= BT_FIRST;
            base_q  <= '0;
            order_q <= order_e'(mode_i);
        end else begin
            beat_q <= beat_d;
            if (load_i) begin
                base_q <= addr_i;
            end
        end
    end

    // Next-state: LOAD, STEP, WRAP, HOLD.
    always_comb begin
        beat_d = beat_q;
        if (load_i) begin
            beat_d = BT_FIRST;
        end else if (adv_i) begin
            unique case (beat_q)
                BT_FIRST:  beat_d = BT_SECOND;
                BT_SECOND: beat_d = BT_THIRD;
                BT_THIRD:  beat_d = BT_FOURTH;
                BT_FOURTH: beat_d = BT_FIRST;
            endcase
        end
    end

    // Output process: form the beat address from base and beat index.
    assign beat_idx = beat_q;

    always_comb begin
        low_bits = base_q[1:0];
        unique case (order_q)
            ORD_INTERLEAVE: low_bits = base_q[1:0] ^ beat_idx;
            ORD_LINEAR:     low_bits = base_q[1:0] + beat_idx;
        endcase
        addr_o = {base_q[ADDR_W-1:2], low_bits};
    end

    // R1
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(addr_i)));

    // R2
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_i) |=> $stable(addr_o));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (order_q == ORD_LINEAR && adv_i && !load_i)
            |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

    // R3
    interleave_step_chk: assert property (@(posedge clk) disable iff (rst)
        (order_q == ORD_INTERLEAVE && beat_q == BT_FIRST && adv_i && !load_i)
            |=> (addr_o[1:0] == ($past(addr_o[1:0]) ^ 2'b01)));

    // R10
    order_locked_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(order_q));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (beat_q == BT_FIRST && base_q == '0));

    initial begin
        assert (HI_W >= 1) else $error("ADDR_W must exceed 2");
    end

endmodule

// File: rtl/lane_write_decode.sv
module lane_write_decode #(
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        strb_n,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES-1:0]        we_q,
    output logic [LANES*LANE_W-1:0] wdata_q
);

    logic [LANES-1:0] we_d;

    // Priority decode: all-lane write first, then enable-qualified strobes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (!all_wr_n) begin
                we_d[g] = 1'b1;
            end else if (!lane_wr_en_n) begin
                we_d[g] = !strb_n[g];
            end else begin
                we_d[g] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= '0;
            wdata_q <= '0;
        end else begin
            we_q    <= we_d;
            wdata_q <= wdata_i;
        end
    end

    // R6
    all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !all_wr_n |=> (we_q == '1));

    // R7
    read_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (all_wr_n && lane_wr_en_n) |=> (we_q == '0));

    // R8
    lane_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (all_wr_n && !lane_wr_en_n) |=> (we_q == ~$past(strb_n)));

    // R11
    reset_we_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (we_q == '0));

endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_ok,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per lane so each lane writes independently.
    for (genvar g = 0; g < LANES; g++) begin : g_col
        logic [LANE_W-1:0] col [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_ok && we[g]) begin
                col[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = col[addr];
    end

endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    order_mode,
    input  logic                    addr_load,
    input  logic                    addr_adv,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_strb_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [ADDR_W-1:0]       burst_addr
);

    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0]  we_q;
    logic [DATA_W-1:0] wdata_q;

    burst_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .mode_i (order_mode),
        .load_i (addr_load),
        .adv_i  (addr_adv),
        .addr_i (addr_in),
        .addr_o (burst_addr)
    );

    lane_write_decode #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_dec (
        .clk          (clk),
        .rst          (rst),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .strb_n       (lane_strb_n),
        .wdata_i      (wdata),
        .we_q         (we_q),
        .wdata_q      (wdata_q)
    );

    lane_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk   (clk),
        .wr_ok (!rst),
        .addr  (burst_addr),
        .we    (we_q),
        .wdata (wdata_q),
        .rdata (rdata)
    );

endmodule

// File: tb/tb_burst_sram_front.sv
`timescale 1ns/1ps
module tb_burst_sram_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        order_mode = 1'b1;
    logic        addr_load = 1'b0;
    logic        addr_adv = 1'b0;
    logic [7:0]  addr_in = '0;
    logic        all_wr_n = 1'b1;
    logic        lane_wr_en_n = 1'b1;
    logic [1:0]  lane_strb_n = 2'b11;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic [7:0]  burst_addr;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_sram_front dut (
        .clk          (clk),
        .rst          (rst),
        .order_mode   (order_mode),
        .addr_load    (addr_load),
        .addr_adv     (addr_adv),
        .addr_in      (addr_in),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_strb_n  (lane_strb_n),
        .wdata        (wdata),
        .rdata        (rdata),
        .burst_addr   (burst_addr)
    );

    // Requirement-level model
    logic        m_mode;
    logic [7:0]  m_base;
    int          m_beat;
    logic [1:0]  m_pend_we;
    logic [17:0] m_pend_d;
    logic [17:0] m_mem [256];
    logic [1:0]  m_known [256];

    // Scoreboard queues
    logic [7:0]  q_addr [$];
    logic [17:0] q_data [$];
    logic [1:0]  q_mask [$];
    string       q_tag  [$];

    function automatic logic [7:0] model_addr();
        logic [1:0] lo;
        if (m_mode) lo = m_base[1:0] ^ 2'(m_beat);
        else        lo = 2'(m_base[1:0] + 2'(m_beat));
        return {m_base[7:2], lo};
    endfunction

    task automatic push_expect(input string tag);
        logic [7:0] ea;
        ea = model_addr();
        q_addr.push_back(ea);
        q_data.push_back(m_mem[ea]);
        q_mask.push_back(m_known[ea]);
        q_tag.push_back(tag);
    endtask

    task automatic drive(input logic ld, input logic adv, input logic [7:0] a,
                         input logic gw_n, input logic be_n, input logic [1:0] st_n,
                         input logic [17:0] d, input string tag);
        logic [7:0] ca;
        @(negedge clk);
        rst = 1'b0;
        addr_load = ld; addr_adv = adv; addr_in = a;
        all_wr_n = gw_n; lane_wr_en_n = be_n; lane_strb_n = st_n; wdata = d;
        ca = model_addr();
        for (int l = 0; l < 2; l++) begin
            if (m_pend_we[l]) begin
                m_mem[ca][l*9 +: 9] = m_pend_d[l*9 +: 9];
                m_known[ca][l] = 1'b1;
            end
        end
        if (ld) begin
            m_base = a; m_beat = 0;
        end else if (adv) begin
            m_beat = (m_beat + 1) % 4;
        end
        if (!gw_n)      m_pend_we = 2'b11;
        else if (!be_n) m_pend_we = ~st_n;
        else            m_pend_we = 2'b00;
        m_pend_d = d;
        push_expect(tag);
    endtask

    task automatic rd(input logic ld, input logic adv, input logic [7:0] a, input string tag);
        drive(ld, adv, a, 1'b1, 1'b1, 2'b00, 18'h0, tag);
    endtask

    task automatic do_reset(input logic mode);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            rst = 1'b1; order_mode = mode;
            addr_load = 1'b0; addr_adv = 1'b0;
            all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_strb_n = 2'b11;
            m_mode = mode; m_base = '0; m_beat = 0; m_pend_we = 2'b00;
            push_expect("R11");
        end
    endtask

    // Monitor: compares one entry per edge, 2 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_addr.size() > 0) begin
                logic [7:0]  ea;
                logic [17:0] ed;
                logic [1:0]  em;
                string       tg;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                em = q_mask.pop_front();
                tg = q_tag.pop_front();
                compared++;
                if (burst_addr !== ea) begin
                    mismatched++;
                    $display("FAIL %s burst_addr actual=%h expected=%h", tg, burst_addr, ea);
                end
                for (int l = 0; l < 2; l++) begin
                    if (em[l]) begin
                        compared++;
                        if (rdata[l*9 +: 9] !== ed[l*9 +: 9]) begin
                            mismatched++;
                            $display("FAIL R9/%s rdata lane%0d @%h actual=%h expected=%h",
                                     tg, l, ea, rdata[l*9 +: 9], ed[l*9 +: 9]);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_mem[i] = '0;
            m_known[i] = 2'b00;
        end
        m_pend_d = '0;

        // R11 reset state, interleaved order selected (R3)
        do_reset(1'b1);

        // R1 load with all-lane write, R6 and R3 over the burst (start 01)
        drive(1'b1, 1'b0, 8'h11, 1'b0, 1'b1, 2'b11, 18'h2A5A5, "R1");
        drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 2'b00, 18'h1F00F, "R3");
        drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 2'b11, 18'h00ABC, "R6");
        drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 2'b11, 18'h3C3C3, "R3");
        // R5 wrap back to first beat, R7 reads with strobes low
        rd(1'b0, 1'b1, 8'h00, "R5");
        rd(1'b0, 1'b1, 8'h00, "R7");
        rd(1'b0, 1'b1, 8'h00, "R7");
        rd(1'b0, 1'b1, 8'h00, "R7");
        rd(1'b0, 1'b0, 8'h00, "R2");
        rd(1'b0, 1'b0, 8'h00, "R2");

        // R8 lane subsets at 0x12
        drive(1'b1, 1'b0, 8'h12, 1'b1, 1'b0, 2'b10, 18'h3FFFF, "R8");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b11, 18'h00000, "R8");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b01, 18'h00000, "R8");
        rd(1'b0, 1'b0, 8'h00, "R8");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b00, 18'h12345, "R8");
        rd(1'b0, 1'b0, 8'h00, "R8");
        drive(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 2'b00, 18'h0BEEF, "R7");
        rd(1'b0, 1'b0, 8'h00, "R7");

        // R1 restart in mid-burst
        rd(1'b1, 1'b0, 8'h40, "R1");
        rd(1'b0, 1'b1, 8'h00, "R3");
        rd(1'b1, 1'b0, 8'h43, "R1");
        rd(1'b0, 1'b1, 8'h00, "R3");
        rd(1'b0, 1'b1, 8'h00, "R3");
        rd(1'b0, 1'b1, 8'h00, "R3");

        // R11 write captured just before reset is dropped
        drive(1'b1, 1'b0, 8'h12, 1'b0, 1'b1, 2'b11, 18'h0AAAA, "R11");
        do_reset(1'b0);
        rd(1'b1, 1'b0, 8'h12, "R11");

        // R4 linear order, start 10
        drive(1'b1, 1'b0, 8'h26, 1'b0, 1'b1, 2'b11, 18'h11111, "R4");
        drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 2'b11, 18'h22222, "R4");
        drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 2'b11, 18'h33333, "R4");
        drive(1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 2'b11, 18'h04444, "R4");
        rd(1'b0, 1'b1, 8'h00, "R5");
        for (int i = 0; i < 7; i++) rd(1'b0, 1'b1, 8'h00, "R5");

        // R10 mode change after reset has no effect
        @(negedge clk);
        order_mode = 1'b1;
        rd(1'b1, 1'b0, 8'h31, "R10");
        rd(1'b0, 1'b1, 8'h00, "R10");
        rd(1'b0, 1'b1, 8'h00, "R10");
        rd(1'b0, 1'b1, 8'h00, "R10");

        // Back to interleaved, start 10 and 11
        do_reset(1'b1);
        rd(1'b1, 1'b0, 8'h26, "R3");
        for (int i = 0; i < 4; i++) rd(1'b0, 1'b1, 8'h00, "R3");
        rd(1'b1, 1'b0, 8'hE7, "R3");
        for (int i = 0; i < 5; i++) rd(1'b0, 1'b1, 8'h00, "R3");

        rd(1'b0, 1'b0, 8'h00, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule